// File: doc/BRIEF.md
# DRAM Bank Row/Column Sequencer

This block drives a single DRAM bank. It accepts read and write requests on a valid/ready port, each carrying a row, a column and, for writes, one data word. It turns each request into the command steps the bank needs: precharge, row activate and column access. Row and column addresses leave on one shared address bus, each in the cycle of the command that uses it.

The sequencer keeps the last activated row open. A later request to that same row goes straight to the column command. A request to a different row first closes the open row with a precharge, then activates the new row, then issues the column command. The wait after each command is a parameter, counted in clock cycles: precharge-to-activate, activate-to-column, and column-to-data.

Read data comes back on the DRAM data input a fixed number of cycles after the read command. The block registers that word and returns it to the requester with a valid strobe. Only one request is in flight at a time, so reads return in request order.

Top module: `dram_row_seq`

## Requirements
- R1: After reset, req_ready is 1, cmd_o is NOP (code 0), rd_valid is 0 and no row is open. The first request therefore activates its row with no precharge before it.
- R2: When no row is open, an accepted request puts ACT (code 1) on cmd_o in the next cycle, with the row on dram_addr. Its column command follows exactly T_RCD cycles later, with NOP in between.
- R3: A request to the open row issues its column command in the cycle after acceptance. No ACT and no PRE come before it.
- R4: A request to a row other than the open one issues PRE (code 4, dram_addr 0) in the cycle after acceptance. ACT with the new row follows T_RP cycles later, and the column command follows T_RCD cycles after the ACT.
- R5: The column command is RD (code 2) for a read and WR (code 3) for a write, with the column zero-extended on dram_addr. During a WR cycle, dram_wdata holds the request's write data.
- R6: dram_rdata is sampled at the end of the cycle that lies T_CL cycles after an RD command. It appears on rd_data with rd_valid high for one cycle, T_CL+1 cycles after the RD. A write never raises rd_valid.
- R7: req_ready is high only while the sequencer is idle and cmd_o is NOP. After a column command it returns high exactly T_CL cycles later.
- R8: ACT is never issued while a row is open.
- R9: A column command is issued only while a row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_wdata | input | DATA_W | Write data |
| cmd_o | output | 3 | Command: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| dram_wdata | output | DATA_W | Write data, valid with WR |
| dram_rdata | input | DATA_W | Read data from the bank |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Returned read data |

## Verification
The bound checker keeps its own copy of the bank state, rebuilt only from the command stream. On every cycle it checks that no ACT lands on an open row and that no column command lands on a closed one. It also checks the PRE-to-ACT and ACT-to-column spacing, the position of each read strobe relative to its RD, and that req_ready coincides with a quiet command bus. Only the directed scenarios can show that the row and column values, the write data and the returned read word are correct. They also show which command path each request takes (hit, miss, or no row open) and the exact cycle in which req_ready rises again.

// File: rtl/drs_pkg.sv
package drs_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } drs_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE_WAIT,
      ST_ACT_WAIT,
      ST_COL_WAIT
   } drs_state_e;

   function automatic int max3(int a, int b, int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/drs_wait_timer.sv
module drs_wait_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/drs_row_tracker.sv
module drs_row_tracker #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_en,
   input  logic [ROW_W-1:0] open_row,
   input  logic             close_en,
   input  logic [ROW_W-1:0] probe_row,
   output logic             is_open,
   output logic             is_hit
);
   logic [ROW_W-1:0] row_q;
   logic             open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (close_en) begin
         open_q <= 1'b0;
      end else if (open_en) begin
         open_q <= 1'b1;
         row_q  <= open_row;
      end
   end

   assign is_open = open_q;
   assign is_hit  = open_q && (row_q == probe_row);
endmodule

// File: rtl/drs_rdata_pipe.sv
module drs_rdata_pipe #(
   parameter int LAT    = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [DATA_W-1:0] bus_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   logic due;

   generate
      if (LAT == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= launch;
         end
         assign due = stage_q;
      end else begin : g_shift
         logic [LAT-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= {stage_q[LAT-2:0], launch};
         end
         assign due = stage_q[LAT-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= due;
         if (due) out_data <= bus_data;
      end
   end
endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq #(
   parameter int ROW_W  = 12,
   parameter int COL_W  = 9,
   parameter int DATA_W = 16,
   parameter int T_RCD  = 3,
   parameter int T_CL   = 4,
   parameter int T_RP   = 3
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      req_valid,
   output logic                                      req_ready,
   input  logic                                      req_write,
   input  logic [ROW_W-1:0]                          req_row,
   input  logic [COL_W-1:0]                          req_col,
   input  logic [DATA_W-1:0]                         req_wdata,
   output logic [2:0]                                cmd_o,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
   output logic [DATA_W-1:0]                         dram_wdata,
   input  logic [DATA_W-1:0]                         dram_rdata,
   output logic                                      rd_valid,
   output logic [DATA_W-1:0]                         rd_data
);
   import drs_pkg::*;

   localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int T_MAX  = max3(T_RCD, T_CL, T_RP);
   localparam int CNT_W  = $clog2(T_MAX + 1);

   generate
      if (!(DATA_W == 4 || DATA_W == 8 || DATA_W == 16 || DATA_W == 32)) begin : g_bad_width
         $error("DATA_W must be 4, 8, 16 or 32");
      end
      if (T_RCD < 1 || T_CL < 1 || T_RP < 1) begin : g_bad_timing
         $error("every wait count must be at least 1");
      end
      if (ROW_W < 1 || COL_W < 1) begin : g_bad_addr
         $error("address widths must be positive");
      end
   endgenerate

   drs_state_e        state_q, state_n;
   logic              lat_write;
   logic [ROW_W-1:0]  lat_row;
   logic [COL_W-1:0]  lat_col;
   logic [DATA_W-1:0] lat_wdata;

   drs_cmd_e          cmd_q, cmd_n;
   logic [ADDR_W-1:0] addr_q, addr_n;
   logic [DATA_W-1:0] wdata_q, wdata_n;

   logic              take;
   logic              tm_load, tm_done;
   logic [CNT_W-1:0]  tm_val;
   logic              row_open, row_hit;

   logic              sel_write;
   logic [COL_W-1:0]  sel_col;
   logic [DATA_W-1:0] sel_wdata;

   assign sel_write = take ? req_write : lat_write;
   assign sel_col   = take ? req_col   : lat_col;
   assign sel_wdata = take ? req_wdata : lat_wdata;

   assign req_ready = (state_q == ST_IDLE);

   always_comb begin
      state_n = state_q;
      cmd_n   = CMD_NOP;
      addr_n  = '0;
      wdata_n = wdata_q;
      tm_load = 1'b0;
      tm_val  = '0;
      take    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               take    = 1'b1;
               tm_load = 1'b1;
               if (row_hit) begin
                  cmd_n   = sel_write ? CMD_WR : CMD_RD;
                  addr_n  = ADDR_W'(sel_col);
                  wdata_n = sel_wdata;
                  tm_val  = CNT_W'(T_CL - 1);
                  state_n = ST_COL_WAIT;
               end else if (row_open) begin
                  cmd_n   = CMD_PRE;
                  tm_val  = CNT_W'(T_RP - 1);
                  state_n = ST_PRE_WAIT;
               end else begin
                  cmd_n   = CMD_ACT;
                  addr_n  = ADDR_W'(req_row);
                  tm_val  = CNT_W'(T_RCD - 1);
                  state_n = ST_ACT_WAIT;
               end
            end
         end
         ST_PRE_WAIT: begin
            if (tm_done) begin
               cmd_n   = CMD_ACT;
               addr_n  = ADDR_W'(lat_row);
               tm_load = 1'b1;
               tm_val  = CNT_W'(T_RCD - 1);
               state_n = ST_ACT_WAIT;
            end
         end
         ST_ACT_WAIT: begin
            if (tm_done) begin
               cmd_n   = sel_write ? CMD_WR : CMD_RD;
               addr_n  = ADDR_W'(sel_col);
               wdata_n = sel_wdata;
               tm_load = 1'b1;
               tm_val  = CNT_W'(T_CL - 1);
               state_n = ST_COL_WAIT;
            end
         end
         ST_COL_WAIT: begin
            if (tm_done) state_n = ST_IDLE;
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cmd_q     <= CMD_NOP;
         addr_q    <= '0;
         wdata_q   <= '0;
         lat_write <= 1'b0;
         lat_row   <= '0;
         lat_col   <= '0;
         lat_wdata <= '0;
      end else begin
         state_q <= state_n;
         cmd_q   <= cmd_n;
         addr_q  <= addr_n;
         wdata_q <= wdata_n;
         if (take) begin
            lat_write <= req_write;
            lat_row   <= req_row;
            lat_col   <= req_col;
            lat_wdata <= req_wdata;
         end
      end
   end

   drs_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .done     (tm_done)
   );

   drs_row_tracker #(.ROW_W(ROW_W)) u_rows (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_en   (cmd_n == CMD_ACT),
      .open_row  (addr_n[ROW_W-1:0]),
      .close_en  (cmd_n == CMD_PRE),
      .probe_row (req_row),
      .is_open   (row_open),
      .is_hit    (row_hit)
   );

   drs_rdata_pipe #(.LAT(T_CL), .DATA_W(DATA_W)) u_rpipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (cmd_q == CMD_RD),
      .bus_data  (dram_rdata),
      .out_valid (rd_valid),
      .out_data  (rd_data)
   );

   assign cmd_o      = cmd_q;
   assign dram_addr  = addr_q;
   assign dram_wdata = wdata_q;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
   parameter int T_RCD = 3,
   parameter int T_CL  = 4,
   parameter int T_RP  = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] cmd_o,
   input logic       req_valid,
   input logic       req_ready,
   input logic       rd_valid
);
   localparam int SAT = 100000;

   logic       sh_open;
   logic [2:0] sh_last;
   int         sh_since_cmd;
   int         sh_since_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_open      <= 1'b0;
         sh_last      <= 3'd0;
         sh_since_cmd <= SAT;
         sh_since_rd  <= SAT;
      end else begin
         if (cmd_o == 3'd1) sh_open <= 1'b1;
         if (cmd_o == 3'd4) sh_open <= 1'b0;
         if (cmd_o != 3'd0) begin
            sh_last      <= cmd_o;
            sh_since_cmd <= 1;
         end else if (sh_since_cmd < SAT) begin
            sh_since_cmd <= sh_since_cmd + 1;
         end
         if (cmd_o == 3'd2)          sh_since_rd <= 1;
         else if (sh_since_rd < SAT) sh_since_rd <= sh_since_rd + 1;
      end
   end

   p_act_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 3'd1) |-> !sh_open);

   p_col_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 3'd2 || cmd_o == 3'd3) |-> sh_open);

   p_pre_to_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 3'd1 && sh_last == 3'd4) |-> (sh_since_cmd == T_RP));

   p_act_to_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_o == 3'd2 || cmd_o == 3'd3) && sh_last == 3'd1) |-> (sh_since_cmd == T_RCD));

   p_read_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (sh_since_rd == T_CL + 1));

   p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cmd_o == 3'd0));

   p_accept_issues_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (cmd_o != 3'd0));
endmodule

bind dram_row_seq drs_checker #(.T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_o     (cmd_o),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rd_valid  (rd_valid)
);

// File: tb/dram_row_seq_test.sv
module dram_row_seq_test;
   localparam int ROW_W  = 12;
   localparam int COL_W  = 9;
   localparam int DATA_W = 16;
   localparam int T_RCD  = 3;
   localparam int T_CL   = 4;
   localparam int T_RP   = 2;
   localparam int ADDR_W = 12;

   localparam int K_CLOSED = 0;
   localparam int K_HIT    = 1;
   localparam int K_MISS   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [ROW_W-1:0]  req_row = '0;
   logic [COL_W-1:0]  req_col = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic [2:0]        cmd_o;
   logic [ADDR_W-1:0] dram_addr;
   logic [DATA_W-1:0] dram_wdata;
   logic [DATA_W-1:0] dram_rdata = 16'hDEAD;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   dram_row_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                  .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_row(req_row), .req_col(req_col),
      .req_wdata(req_wdata), .cmd_o(cmd_o), .dram_addr(dram_addr),
      .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
         finish_run();
      end
   end

   // Check the command in this cycle, then the NOP gap that follows it.
   task automatic expect_step(input logic [2:0] c, input logic [ADDR_W-1:0] a,
                              input int gap, input string tag);
      chk(cmd_o == c, tag, "command code", cmd_o, c);
      chk(dram_addr == a, tag, "address bus", dram_addr, a);
      for (int i = 1; i < gap; i++) begin
         @(negedge clk);
         chk(cmd_o == 3'd0, tag, "NOP in wait gap", cmd_o, 0);
      end
      @(negedge clk);
   endtask

   task automatic access(input bit wr, input logic [ROW_W-1:0] row,
                         input logic [COL_W-1:0] col, input logic [DATA_W-1:0] wd,
                         input logic [DATA_W-1:0] rv, input int kind);
      int guard = 0;
      while (!req_ready && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      req_valid = 1'b1; req_write = wr; req_row = row; req_col = col; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_wdata = ~wd;
      if (kind == K_MISS) begin
         expect_step(3'd4, '0, T_RP, "R4/R8 precharge");
         expect_step(3'd1, ADDR_W'(row), T_RCD, "R4 activate");
      end else if (kind == K_CLOSED) begin
         expect_step(3'd1, ADDR_W'(row), T_RCD, "R2/R9 activate");
      end
      chk(cmd_o == (wr ? 3'd3 : 3'd2), kind == K_HIT ? "R3/R5" : "R5",
          "column command", cmd_o, wr ? 3 : 2);
      chk(dram_addr == ADDR_W'(col), "R5", "column address", dram_addr, col);
      if (wr) chk(dram_wdata == wd, "R5", "write data", dram_wdata, wd);
      for (int k = 1; k < T_CL; k++) begin
         @(negedge clk);
         chk(req_ready == 1'b0, "R7", "ready low while busy", req_ready, 0);
         chk(cmd_o == 3'd0, "R7", "NOP after column", cmd_o, 0);
      end
      @(negedge clk);
      chk(req_ready == 1'b1, "R7", "ready back after T_CL", req_ready, 1);
      if (!wr) dram_rdata = rv;
      @(negedge clk);
      chk(rd_valid == !wr, "R6", "read strobe", rd_valid, !wr);
      if (!wr) chk(rd_data == rv, "R6", "returned data", rd_data, rv);
      dram_rdata = 16'hDEAD;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
         chk(cmd_o == 3'd0, "R1", "NOP after reset", cmd_o, 0);
         chk(rd_valid == 1'b0, "R1", "no strobe after reset", rd_valid, 0);
      end
   endtask

   task automatic t_first_read();   // R1 R2 R6: no precharge on first use
      access(1'b0, 12'h12A, 9'h005, 16'h0000, 16'hA5C3, K_CLOSED);
   endtask

   task automatic t_hit_write();    // R3 R5
      access(1'b1, 12'h12A, 9'h1FF, 16'h3C5A, 16'h0000, K_HIT);
   endtask

   task automatic t_hit_read();     // R3 R6
      access(1'b0, 12'h12A, 9'h000, 16'h0000, 16'h1234, K_HIT);
   endtask

   task automatic t_miss_write();   // R4 R8
      access(1'b1, 12'h003, 9'h040, 16'hBEEF, 16'h0000, K_MISS);
   endtask

   task automatic t_miss_read_edge(); // R4 R6 at the top row/column
      access(1'b0, 12'hFFF, 9'h100, 16'h0000, 16'hFFFF, K_MISS);
      access(1'b0, 12'hFFF, 9'h1FE, 16'h0000, 16'h0001, K_HIT);
   endtask

   task automatic t_back_to_first(); // R4 R9 return to a closed row
      access(1'b0, 12'h12A, 9'h005, 16'h0000, 16'h5A5A, K_MISS);
      access(1'b1, 12'h12A, 9'h006, 16'h8001, 16'h0000, K_HIT);
   endtask

   initial begin
      t_reset();
      t_first_read();
      t_hit_write();
      t_hit_read();
      t_miss_write();
      t_miss_read_edge();
      t_back_to_first();
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule